// File: doc/BRIEF.md
# NAND Read Address Pointer

This block is the device-side pointer logic for a small-page NAND memory read. It receives one-cycle decoded command strobes for the three read regions: the lower main half, the upper main half and the spare area. It also receives a stream of three address bytes, a read pulse and an active-low chip enable. From these it keeps the column being read and the page being read, and it marks the interval in which a page is loaded into the data register.

A page holds 528 columns. Columns 0 to 511 form the main area and columns 512 to 527 form the spare area. Each accepted read pulse steps the column by one. Stepping past the end of the region moves to the next page and starts a fresh load. That load lasts a parameterised number of clock cycles. The reload request output tells the array stub when to fetch the new page.

If chip enable is released while a load is in progress, the read is abandoned and the block enters standby. The array itself and the contents of the data register are not part of this block.

Top module: `nrp_top`

## Requirements
- R1: After reset, colAddr is 0, pageAddr is 0, busy, standby and reloadReq are 0, and the region is the lower main half.
- R2: The third address byte accepted after a command (byte 0 = column, byte 1 = page low, byte 2 = page high) loads colAddr and pageAddr at that clock edge. busy rises at the same edge and stays high for exactly LOAD_CYC cycles. reloadReq is high only in the first of those cycles.
- R3: With the upper-main command, the starting column is 256 plus byte 0.
- R4: With the spare command, the starting column is 512 plus bits 3..0 of byte 0, and bits 7..4 are ignored. colAddr never exceeds 527.
- R5: A read pulse advances colAddr by one at the next edge, but only once a load has completed. Read pulses are ignored while busy, while in standby, while chip enable is high, and before any load. colAddr and pageAddr hold while busy.
- R6: In a main region, a read at column 511 sets the column to 0, increments the page and starts a new load.
- R7: In the spare region, a read at column 527 sets the column to 512, increments the page and starts a new load. The region stays spare across such wraps until a main command is given.
- R8: If chip enable is high while busy, busy falls and standby rises at the next edge. Standby is cleared by the next command.
- R9: The page address wraps from its highest value (all ones, PAGE_W bits) to 0.
- R10: Commands arriving while busy are ignored. Address bytes beyond the third are ignored.
- R11: Without any command after reset, address bytes are taken in the lower main region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| cmdMainLo | input | 1 | One-cycle strobe: read from lower main half |
| cmdMainHi | input | 1 | One-cycle strobe: read from upper main half |
| cmdSpare | input | 1 | One-cycle strobe: read from spare area |
| addrValid | input | 1 | Address byte present on addrByte |
| addrByte | input | 8 | Address byte value |
| rdPulse | input | 1 | One-cycle read pulse |
| colAddr | output | 10 | Current column (0..527) |
| pageAddr | output | PAGE_W | Current page |
| busy | output | 1 | Page load in progress |
| standby | output | 1 | Read abandoned, waiting for a command |
| reloadReq | output | 1 | One-cycle request to load the page register |

## Verification
A table drives each of the three commands with address bytes whose columns and pages differ. This shows the half offset of 256, the four-bit spare select with its masked upper nibble, and the page byte order. Directed sequences then approach the last column of each region, to tell the main wrap to column 0 from the spare wrap to column 512. A run of reads after a spare wrap shows that the region persists. The page wrap is driven from an all-ones page. Read pulses and commands given during a load, an extra address byte, and a chip-enable release during a load each show that the pointer is left untouched.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

  typedef enum logic [1:0] {
    REG_MAIN_LO = 2'd0,
    REG_MAIN_HI = 2'd1,
    REG_SPARE   = 2'd2
  } region_e;

  typedef struct packed {
    region_e region;
    logic    captureB0;
    logic    captureB1;
    logic    commit;
    logic    stepCol;
  } dpStrobe_t;

endpackage

// File: rtl/nrp_ctrl.sv
module nrp_ctrl
  import nrp_pkg::*;
#(
  parameter int LOAD_CYC = 350
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      cmdMainLo,
  input  logic      cmdMainHi,
  input  logic      cmdSpare,
  input  logic      addrValid,
  input  logic      rdPulse,
  input  logic      atEnd,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      standby,
  output logic      reloadReq
);
  localparam int CNT_W = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(LOAD_CYC - 1);

  region_e          regionQ;
  logic [1:0]       byteCnt;
  logic [CNT_W-1:0] loadCnt;
  logic             readyQ;
  logic             cmdAny;
  logic             addrOk;
  logic             rdOk;
  logic             startLoad;
  logic             abort;

  always_comb begin
    cmdAny    = (cmdMainLo | cmdMainHi | cmdSpare) & ~busy;
    addrOk    = addrValid & ~busy & ~cmdAny & (byteCnt != 2'd3);
    rdOk      = rdPulse & readyQ & ~busy & ~standby & ~ceN & ~cmdAny & ~addrOk;
    abort     = busy & ceN;
    startLoad = (addrOk & (byteCnt == 2'd2)) | (rdOk & atEnd);

    strobe.region    = regionQ;
    strobe.captureB0 = addrOk & (byteCnt == 2'd0);
    strobe.captureB1 = addrOk & (byteCnt == 2'd1);
    strobe.commit    = addrOk & (byteCnt == 2'd2);
    strobe.stepCol   = rdOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionQ   <= REG_MAIN_LO;
      byteCnt   <= 2'd0;
      loadCnt   <= '0;
      busy      <= 1'b0;
      standby   <= 1'b0;
      readyQ    <= 1'b0;
      reloadReq <= 1'b0;
    end else begin
      reloadReq <= startLoad;
      if (abort) begin
        busy    <= 1'b0;
        standby <= 1'b1;
        readyQ  <= 1'b0;
      end else if (busy) begin
        if (loadCnt == '0) begin
          busy   <= 1'b0;
          readyQ <= 1'b1;
        end else begin
          loadCnt <= loadCnt - 1'b1;
        end
      end else begin
        if (startLoad) begin
          busy    <= 1'b1;
          loadCnt <= CNT_START;
        end
        if (cmdAny) begin
          byteCnt <= 2'd0;
          standby <= 1'b0;
          readyQ  <= 1'b0;
          if (cmdSpare)       regionQ <= REG_SPARE;
          else if (cmdMainHi) regionQ <= REG_MAIN_HI;
          else                regionQ <= REG_MAIN_LO;
        end else if (addrOk) begin
          byteCnt <= byteCnt + 2'd1;
          if (byteCnt == 2'd2) readyQ <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/nrp_datapath.sv
module nrp_datapath
  import nrp_pkg::*;
#(
  parameter int MAIN_COLS  = 512,
  parameter int SPARE_COLS = 16,
  parameter int PAGE_W     = 16
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  dpStrobe_t                                     strobe,
  input  logic [7:0]                                    addrByte,
  output logic [$clog2(MAIN_COLS+SPARE_COLS)-1:0]       colAddr,
  output logic [PAGE_W-1:0]                             pageAddr,
  output logic                                          atEnd
);
  localparam int COL_W       = $clog2(MAIN_COLS + SPARE_COLS);
  localparam int HALF        = MAIN_COLS / 2;
  localparam int SPARE_SEL_W = $clog2(SPARE_COLS);
  localparam logic [COL_W-1:0] LAST_MAIN  = COL_W'(MAIN_COLS - 1);
  localparam logic [COL_W-1:0] LAST_SPARE = COL_W'(MAIN_COLS + SPARE_COLS - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_COLS);

  logic [7:0]       b0Q;
  logic [7:0]       b1Q;
  logic [COL_W-1:0] colQ;
  logic [PAGE_W-1:0] pageQ;
  logic [COL_W-1:0] colStart;
  logic [15:0]      rawPage;
  logic             isSpare;

  always_comb begin
    isSpare = (strobe.region == REG_SPARE);
    rawPage = {addrByte, b1Q};
    unique case (strobe.region)
      REG_MAIN_HI: colStart = COL_W'(HALF) + COL_W'(b0Q);
      REG_SPARE:   colStart = SPARE_BASE + COL_W'(b0Q[SPARE_SEL_W-1:0]);
      default:     colStart = COL_W'(b0Q);
    endcase
    atEnd = isSpare ? (colQ == LAST_SPARE) : (colQ == LAST_MAIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      b0Q   <= '0;
      b1Q   <= '0;
      colQ  <= '0;
      pageQ <= '0;
    end else begin
      if (strobe.captureB0) b0Q <= addrByte;
      if (strobe.captureB1) b1Q <= addrByte;
      if (strobe.commit) begin
        colQ  <= colStart;
        pageQ <= rawPage[PAGE_W-1:0];
      end else if (strobe.stepCol) begin
        if (atEnd) begin
          colQ  <= isSpare ? SPARE_BASE : '0;
          pageQ <= pageQ + 1'b1;
        end else begin
          colQ <= colQ + 1'b1;
        end
      end
    end
  end

  assign colAddr  = colQ;
  assign pageAddr = pageQ;

endmodule

// File: rtl/nrp_top.sv
module nrp_top
  import nrp_pkg::*;
#(
  parameter int MAIN_COLS  = 512,
  parameter int SPARE_COLS = 16,
  parameter int PAGE_W     = 16,
  parameter int LOAD_CYC   = 350
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    ceN,
  input  logic                                    cmdMainLo,
  input  logic                                    cmdMainHi,
  input  logic                                    cmdSpare,
  input  logic                                    addrValid,
  input  logic [7:0]                              addrByte,
  input  logic                                    rdPulse,
  output logic [$clog2(MAIN_COLS+SPARE_COLS)-1:0] colAddr,
  output logic [PAGE_W-1:0]                       pageAddr,
  output logic                                    busy,
  output logic                                    standby,
  output logic                                    reloadReq
);
  dpStrobe_t strobe;
  logic      atEnd;

  nrp_ctrl #(.LOAD_CYC(LOAD_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN),
    .cmdMainLo(cmdMainLo), .cmdMainHi(cmdMainHi), .cmdSpare(cmdSpare),
    .addrValid(addrValid), .rdPulse(rdPulse), .atEnd(atEnd),
    .strobe(strobe), .busy(busy), .standby(standby), .reloadReq(reloadReq)
  );

  nrp_datapath #(.MAIN_COLS(MAIN_COLS), .SPARE_COLS(SPARE_COLS), .PAGE_W(PAGE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrByte(addrByte),
    .colAddr(colAddr), .pageAddr(pageAddr), .atEnd(atEnd)
  );

endmodule

// File: rtl/nrp_checker.sv
module nrp_checker #(
  parameter int MAIN_COLS  = 512,
  parameter int SPARE_COLS = 16,
  parameter int PAGE_W     = 16
) (
  input logic                                    clk,
  input logic                                    rstN,
  input logic                                    ceN,
  input logic                                    addrValid,
  input logic [$clog2(MAIN_COLS+SPARE_COLS)-1:0] colAddr,
  input logic [PAGE_W-1:0]                       pageAddr,
  input logic                                    busy,
  input logic                                    standby,
  input logic                                    reloadReq
);
  localparam int COL_W = $clog2(MAIN_COLS + SPARE_COLS);
  localparam logic [COL_W-1:0] LAST_MAIN  = COL_W'(MAIN_COLS - 1);
  localparam logic [COL_W-1:0] LAST_SPARE = COL_W'(MAIN_COLS + SPARE_COLS - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_COLS);

  assert_reload_on_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> reloadReq);

  assert_reload_first_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |-> (busy && !$past(busy)));

  assert_col_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    colAddr <= LAST_SPARE);

  assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(colAddr) && $stable(pageAddr)));

  assert_main_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !$past(addrValid) && $past(colAddr) == LAST_MAIN)
      |-> (colAddr == '0 && pageAddr == PAGE_W'($past(pageAddr) + 1'b1)));

  assert_spare_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !$past(addrValid) && $past(colAddr) == LAST_SPARE)
      |-> (colAddr == SPARE_BASE && pageAddr == PAGE_W'($past(pageAddr) + 1'b1)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ceN) |=> (!busy && standby));

  assert_standby_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> !busy);

endmodule

bind nrp_top nrp_checker #(.MAIN_COLS(MAIN_COLS), .SPARE_COLS(SPARE_COLS), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .addrValid(addrValid),
  .colAddr(colAddr), .pageAddr(pageAddr), .busy(busy),
  .standby(standby), .reloadReq(reloadReq)
);

// File: tb/nrp_top_tb_top.sv
module nrp_top_tb_top;
  localparam int LOAD = 8;
  localparam int PW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b0;
  logic cmdMainLo = 1'b0, cmdMainHi = 1'b0, cmdSpare = 1'b0;
  logic addrValid = 1'b0;
  logic [7:0] addrByte = '0;
  logic rdPulse = 1'b0;
  logic [9:0] colAddr;
  logic [PW-1:0] pageAddr;
  logic busy, standby, reloadReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nrp_top #(.PAGE_W(PW), .LOAD_CYC(LOAD)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN),
    .cmdMainLo(cmdMainLo), .cmdMainHi(cmdMainHi), .cmdSpare(cmdSpare),
    .addrValid(addrValid), .addrByte(addrByte), .rdPulse(rdPulse),
    .colAddr(colAddr), .pageAddr(pageAddr), .busy(busy),
    .standby(standby), .reloadReq(reloadReq)
  );

  // cmd, byte0, byte1, byte2, expected column, expected page
  // cmd: 0 lower main, 1 upper main, 2 spare
  localparam int NVEC = 5;
  localparam logic [51:0] VEC [NVEC] = '{
    {2'd0, 8'h12, 8'h34, 8'h56, 10'd18,  16'h5634},
    {2'd1, 8'h12, 8'h00, 8'h01, 10'd274, 16'h0100},
    {2'd2, 8'hF7, 8'hAA, 8'h00, 10'd519, 16'h00AA},
    {2'd1, 8'h00, 8'hFF, 8'hFF, 10'd256, 16'hFFFF},
    {2'd0, 8'hFF, 8'h01, 8'h80, 10'd255, 16'h8001}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input int k);
    cmdMainLo = (k == 0);
    cmdMainHi = (k == 1);
    cmdSpare  = (k == 2);
    @(negedge clk);
    cmdMainLo = 1'b0; cmdMainHi = 1'b0; cmdSpare = 1'b0;
  endtask

  task automatic addr1(input logic [7:0] b);
    addrValid = 1'b1; addrByte = b;
    @(negedge clk);
    addrValid = 1'b0; addrByte = '0;
  endtask

  task automatic addr3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    addr1(b0); addr1(b1); addr1(b2);
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin
      rdPulse = 1'b1;
      @(negedge clk);
      rdPulse = 1'b0;
    end
  endtask

  task automatic waitLoad(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 col", colAddr, 0);
    chk("R1 page", pageAddr, 0);
    chk("R1 busy", busy, 0);
    chk("R1 standby", standby, 0);
    chk("R1 reload", reloadReq, 0);

    // R5 read before any load is ignored
    rd(1);
    chk("R5 read before load", colAddr, 0);

    // R11 default region without a command; R2 load timing
    addr3(8'h21, 8'h03, 8'h00);
    chk("R11 default col", colAddr, 33);
    chk("R2 page", pageAddr, 3);
    chk("R2 busy rise", busy, 1);
    chk("R2 reload first", reloadReq, 1);
    @(negedge clk);
    chk("R2 reload one cycle", reloadReq, 0);
    waitLoad(n);
    chk("R2 busy length", n + 1, LOAD);
    rd(3);
    chk("R5 step by three", colAddr, 36);

    // Table: R2 R3 R4 by command
    for (int v = 0; v < NVEC; v++) begin
      logic [51:0] e;
      e = VEC[v];
      cmd(int'(e[51:50]));
      addr3(e[49:42], e[41:34], e[33:26]);
      chk($sformatf("R2/R3/R4 vec%0d col", v), colAddr, int'(e[25:16]));
      chk($sformatf("R2 vec%0d page", v), pageAddr, int'(e[15:0]));
      waitLoad(n);
      chk($sformatf("R2 vec%0d busy length", v), n, LOAD);
    end

    // R6 main wrap
    cmd(1);
    addr3(8'hFF, 8'h10, 8'h00);
    chk("R6 start 511", colAddr, 511);
    waitLoad(n);
    rd(1);
    chk("R6 wrap col", colAddr, 0);
    chk("R6 wrap page", pageAddr, 16'h0011);
    chk("R6 reload busy", busy, 1);
    chk("R6 reload req", reloadReq, 1);
    waitLoad(n);
    chk("R6 reload length", n, LOAD);
    rd(1);
    chk("R6 after wrap", colAddr, 1);

    // R7 spare wrap and persistence
    cmd(2);
    addr3(8'hAF, 8'h20, 8'h00);
    chk("R7 start 527", colAddr, 527);
    waitLoad(n);
    rd(1);
    chk("R7 wrap col", colAddr, 512);
    chk("R7 wrap page", pageAddr, 16'h0021);
    chk("R7 reload", busy, 1);
    waitLoad(n);
    rd(15);
    chk("R7 run to 527", colAddr, 527);
    rd(1);
    chk("R7 second wrap col", colAddr, 512);
    chk("R7 second wrap page", pageAddr, 16'h0022);
    waitLoad(n);
    cmd(0);
    addr3(8'h05, 8'h00, 8'h00);
    chk("R7 main command returns", colAddr, 5);
    waitLoad(n);

    // R9 page wrap
    cmd(1);
    addr3(8'hFF, 8'hFF, 8'hFF);
    waitLoad(n);
    rd(1);
    chk("R9 page wrap", pageAddr, 0);
    chk("R9 col", colAddr, 0);
    waitLoad(n);

    // R5 reads during busy, R10 command during busy and extra address byte
    cmd(0);
    addr3(8'h05, 8'h01, 8'h00);
    rd(2);
    cmd(2);
    chk("R5 hold during busy", colAddr, 5);
    waitLoad(n);
    rd(1);
    chk("R10 command while busy ignored", colAddr, 6);
    addr1(8'h80);
    chk("R10 fourth byte col", colAddr, 6);
    chk("R10 fourth byte busy", busy, 0);
    chk("R10 fourth byte page", pageAddr, 1);
    rd(1);
    chk("R10 reads continue", colAddr, 7);

    // R8 abort
    cmd(0);
    addr3(8'h10, 8'h02, 8'h00);
    ceN = 1'b1;
    @(negedge clk);
    ceN = 1'b0;
    chk("R8 busy dropped", busy, 0);
    chk("R8 standby", standby, 1);
    rd(2);
    chk("R8 read in standby ignored", colAddr, 16);
    cmd(0);
    chk("R8 standby cleared", standby, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule